// File: doc/BRIEF.md
# I2C Register Slave with Strapped Device Address

This block is the control port of a mixed-signal device. It is a slave on a two-wire I2C bus and gives a bus master byte-wide access to a small map of configuration and status registers. The 7-bit device address is formed from a fixed base value plus a 3-bit offset. That offset comes from two external four-level straps that are already decoded outside this block. Up to eight such devices can therefore share one bus.

A master writes by sending the device address with a write bit, then a register pointer, then any number of data bytes. The pointer advances after every data byte. To read, the master first writes the pointer and then issues a repeated start with the read bit. The slave then streams bytes from consecutive registers until the master answers a byte with NACK. Both bus lines are brought into the fast system clock domain through two-flop synchronizers. Start and stop conditions are detected from the synchronized samples. SDA is modelled as a received level plus a separate pull-low enable.

Top module: `i2c_strap_regslave`

## Requirements
- R1: The device answers to address 0x6C plus the strap offset (0..7). The address byte carries that 7-bit value in bits 7:1 and R/W in bit 0 (0 = write, 1 = read). On a match the slave holds SDA low through the ninth SCL pulse.
- R2: An address byte that does not match gets no acknowledge. The slave then leaves every register unchanged and does not drive SDA until the next start condition.
- R3: In a write, the byte after the address is loaded into the register pointer and acknowledged. Each following data byte is acknowledged and stored at the pointer, and the pointer then advances by one.
- R4: In a read (pointer write, repeated start, address with R/W = 1), the slave sends the register at the pointer MSB first and advances the pointer after each byte. It continues while the master acknowledges and lets SDA go after a NACK. The slave changes SDA only while SCL is low, except that it releases SDA at a start or stop.
- R5: Register 0x00 always reads 0x12. A write to it is acknowledged and has no effect.
- R6: After reset the registers read 0x01=0xFD, 0x02=0x04, 0x03=0x80, 0x04=0xCF, 0x06=0x51, 0x10=0xFF, 0x11=0xFC, 0x13=0x00, 0x14=0x02 and 0x08=0x00 plus fault bits. SDA is released after reset.
- R7: A write to an address with no register is acknowledged and discarded. A read of such an address returns 0x00.
- R8: In register 0x08, bits 3:0 read the live fault inputs and ignore writes. Bits 5:4 are writable, and bits 7:6 always read 0.
- R9: The pointer wraps from 0xFF to 0x00, for both reads and writes.
- R10: A start condition at any point, even in the middle of a byte, drops the transfer in progress and begins a new address phase.

## Ports
| Port | Direction | Width | Description |
|---|---|---|---|
| clk | input | 1 | System clock, much faster than SCL |
| rst_n | input | 1 | Asynchronous active-low reset |
| strap_ofs | input | 3 | Decoded address strap offset |
| fault_in | input | 4 | Live fault flags shown in register 0x08 bits 3:0 |
| scl_in | input | 1 | SCL level seen on the bus |
| sda_in | input | 1 | SDA level seen on the bus |
| sda_pull | output | 1 | 1 = pull SDA low |
| cfg_flat | output | 80 | Writable registers, 0x01 in bits 7:0 up to 0x14 in bits 79:72 |

## Verification
Every register's reset value is read back through single-byte reads driven from a table. A wrong address tells the ignore path apart from a plain write to the same register. Multi-byte writes and reads starting at 0x01 and at 0xFF separate pointer advance and wrap from a fixed pointer. Writes to 0x00, 0x05 and 0x08 separate the read-only, unimplemented and masked paths. Two different fault input values show that 0x08 reads live status. A start issued four bits into a data byte checks the abort path. Changing the strap at the end shows the address follows the offset.

// File: rtl/i2c_rs_pkg.sv
`timescale 1ns/1ps
package i2c_rs_pkg;
  localparam int BYTE_W = 8;
  localparam int DEV_AW = 7;
  localparam int OFS_W  = 3;
  localparam int FLT_W  = 4;
  localparam logic [DEV_AW-1:0] DEV_BASE = 7'h6C;
  localparam logic [BYTE_W-1:0] ID_ADDR  = 8'h00;
  localparam logic [BYTE_W-1:0] ID_VALUE = 8'h12;
  localparam logic [BYTE_W-1:0] FLT_ADDR = 8'h08;

  localparam int NUM_RW = 10;
  localparam logic [BYTE_W-1:0] RW_ADDR [NUM_RW] =
    '{8'h01, 8'h02, 8'h03, 8'h04, 8'h06, 8'h08, 8'h10, 8'h11, 8'h13, 8'h14};
  localparam logic [BYTE_W-1:0] RW_RST  [NUM_RW] =
    '{8'hFD, 8'h04, 8'h80, 8'hCF, 8'h51, 8'h00, 8'hFF, 8'hFC, 8'h00, 8'h02};
  localparam logic [BYTE_W-1:0] RW_MASK [NUM_RW] =
    '{8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'hFF, 8'h30, 8'hFF, 8'hFF, 8'hFF, 8'hFF};

  typedef enum logic [2:0] {
    ST_IDLE,
    ST_DEV,
    ST_PTR,
    ST_WR,
    ST_RD
  } bus_st_t;
endpackage

// File: rtl/i2c_rs_sync.sv
`timescale 1ns/1ps
module i2c_rs_sync #(
  parameter int N_SIG  = 2,
  parameter int STAGES = 2
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic [N_SIG-1:0] sig_in,
  output logic [N_SIG-1:0] sig_s,
  output logic [N_SIG-1:0] sig_q
);
  localparam int DEPTH = STAGES + 1;

  for (genvar g = 0; g < N_SIG; g++) begin : g_bit
    logic [DEPTH-1:0] pipe_q;
    logic [DEPTH-1:0] pipe_d;

    always_comb begin
      pipe_d = {pipe_q[DEPTH-2:0], sig_in[g]};
    end

    always_ff @(posedge clk or negedge rst_n) begin
      if (!rst_n) pipe_q <= '1;
      else        pipe_q <= pipe_d;
    end

    assign sig_s[g] = pipe_q[STAGES-1];
    assign sig_q[g] = pipe_q[STAGES];
  end
endmodule

// File: rtl/i2c_rs_busevt.sv
`timescale 1ns/1ps
module i2c_rs_busevt (
  input  logic scl_s,
  input  logic scl_q,
  input  logic sda_s,
  input  logic sda_q,
  output logic start_ev,
  output logic stop_ev,
  output logic scl_rise,
  output logic scl_fall
);
  logic scl_hi;

  always_comb begin
    scl_hi   = scl_s & scl_q;
    start_ev = scl_hi & sda_q & ~sda_s;
    stop_ev  = scl_hi & ~sda_q & sda_s;
    scl_rise = scl_s & ~scl_q;
    scl_fall = ~scl_s & scl_q;
  end
endmodule

// File: rtl/i2c_rs_fsm.sv
`timescale 1ns/1ps
module i2c_rs_fsm
  import i2c_rs_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int AW = DEV_AW
) (
  input  logic          clk,
  input  logic          rst_n,
  input  logic          start_ev,
  input  logic          stop_ev,
  input  logic          scl_rise,
  input  logic          scl_fall,
  input  logic          scl_s,
  input  logic          sda_s,
  input  logic [AW-1:0] dev_addr,
  input  logic [DW-1:0] rd_data,
  output logic [DW-1:0] ptr_o,
  output logic          wr_en,
  output logic [DW-1:0] wr_data,
  output logic          sda_pull
);
  localparam int CW = $clog2(DW + 1);
  localparam logic [CW-1:0] LAST = CW'(DW);

  bus_st_t       st_q, st_d;
  logic [CW-1:0] cnt_q, cnt_d;
  logic          ack_q, ack_d;
  logic [DW-1:0] sh_q, sh_d;
  logic [DW-1:0] tx_q, tx_d;
  logic [DW-1:0] ptr_q, ptr_d;
  logic          pull_q, pull_d;
  logic          mack_q, mack_d;

  always_comb begin
    st_d   = st_q;
    cnt_d  = cnt_q;
    ack_d  = ack_q;
    sh_d   = sh_q;
    tx_d   = tx_q;
    ptr_d  = ptr_q;
    pull_d = pull_q;
    mack_d = mack_q;
    wr_en  = 1'b0;
    if (start_ev) begin
      st_d   = ST_DEV;
      cnt_d  = '0;
      ack_d  = 1'b0;
      pull_d = 1'b0;
    end else if (stop_ev) begin
      st_d   = ST_IDLE;
      cnt_d  = '0;
      ack_d  = 1'b0;
      pull_d = 1'b0;
    end else if (st_q != ST_IDLE) begin
      if (scl_rise) begin
        if (ack_q) begin
          if (st_q == ST_RD) mack_d = ~sda_s;
        end else if (cnt_q != LAST) begin
          sh_d  = {sh_q[DW-2:0], sda_s};
          cnt_d = cnt_q + CW'(1);
        end
      end else if (scl_fall) begin
        if (ack_q) begin
          ack_d  = 1'b0;
          cnt_d  = '0;
          pull_d = 1'b0;
          unique case (st_q)
            ST_DEV: begin
              if (sh_q[0]) begin
                st_d   = ST_RD;
                tx_d   = rd_data;
                pull_d = ~rd_data[DW-1];
                ptr_d  = ptr_q + DW'(1);
              end else begin
                st_d = ST_PTR;
              end
            end
            ST_PTR: st_d = ST_WR;
            ST_RD: begin
              if (mack_q) begin
                tx_d   = rd_data;
                pull_d = ~rd_data[DW-1];
                ptr_d  = ptr_q + DW'(1);
              end else begin
                st_d = ST_IDLE;
              end
            end
            default: ;
          endcase
        end else if (cnt_q == LAST) begin
          ack_d = 1'b1;
          unique case (st_q)
            ST_DEV: begin
              if (sh_q[DW-1:1] == dev_addr) begin
                pull_d = 1'b1;
              end else begin
                st_d  = ST_IDLE;
                ack_d = 1'b0;
              end
            end
            ST_PTR: begin
              ptr_d  = sh_q;
              pull_d = 1'b1;
            end
            ST_WR: begin
              wr_en  = 1'b1;
              ptr_d  = ptr_q + DW'(1);
              pull_d = 1'b1;
            end
            ST_RD:   pull_d = 1'b0;
            default: ;
          endcase
        end else if (st_q == ST_RD && cnt_q != '0) begin
          tx_d   = {tx_q[DW-2:0], 1'b0};
          pull_d = ~tx_q[DW-2];
        end
      end
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      st_q   <= ST_IDLE;
      cnt_q  <= '0;
      ack_q  <= 1'b0;
      sh_q   <= '0;
      tx_q   <= '0;
      ptr_q  <= '0;
      pull_q <= 1'b0;
      mack_q <= 1'b0;
    end else begin
      st_q   <= st_d;
      cnt_q  <= cnt_d;
      ack_q  <= ack_d;
      sh_q   <= sh_d;
      tx_q   <= tx_d;
      ptr_q  <= ptr_d;
      pull_q <= pull_d;
      mack_q <= mack_d;
    end
  end

  assign ptr_o    = ptr_q;
  assign wr_data  = sh_q;
  assign sda_pull = pull_q;

  AST_IDLE_QUIET: assert property (@(posedge clk) disable iff (!rst_n)
    (st_q == ST_IDLE) |-> !sda_pull); // R2
  AST_PTR_STEP: assert property (@(posedge clk) disable iff (!rst_n)
    $past(wr_en) |-> (ptr_q == $past(ptr_q) + DW'(1))); // R3
  AST_PULL_EDGE: assert property (@(posedge clk) disable iff (!rst_n)
    (sda_pull != $past(sda_pull)) |-> (!scl_s || $past(start_ev) || $past(stop_ev))); // R4
  AST_START_DEV: assert property (@(posedge clk) disable iff (!rst_n)
    $past(start_ev) |-> (st_q == ST_DEV && cnt_q == '0 && !sda_pull)); // R10
endmodule

// File: rtl/i2c_rs_regfile.sv
`timescale 1ns/1ps
module i2c_rs_regfile
  import i2c_rs_pkg::*;
#(
  parameter int DW = BYTE_W,
  parameter int NR = NUM_RW,
  parameter int FW = FLT_W
) (
  input  logic             clk,
  input  logic             rst_n,
  input  logic             wr_en,
  input  logic [DW-1:0]    wr_addr,
  input  logic [DW-1:0]    wr_data,
  input  logic [DW-1:0]    rd_addr,
  input  logic [FW-1:0]    fault_in,
  output logic [DW-1:0]    rd_data,
  output logic [NR*DW-1:0] cfg_flat
);
  logic [NR-1:0][DW-1:0] regs_q;
  logic [NR-1:0][DW-1:0] regs_d;

  always_comb begin
    for (int i = 0; i < NR; i++) begin
      regs_d[i] = regs_q[i];
      if (wr_en && wr_addr == RW_ADDR[i]) regs_d[i] = wr_data & RW_MASK[i];
    end
  end

  always_ff @(posedge clk or negedge rst_n) begin
    if (!rst_n) begin
      for (int i = 0; i < NR; i++) regs_q[i] <= RW_RST[i];
    end else begin
      regs_q <= regs_d;
    end
  end

  always_comb begin
    rd_data = '0;
    if (rd_addr == ID_ADDR) rd_data = ID_VALUE;
    for (int i = 0; i < NR; i++) begin
      if (rd_addr == RW_ADDR[i]) rd_data = regs_q[i];
    end
    if (rd_addr == FLT_ADDR) rd_data = rd_data | {{(DW-FW){1'b0}}, fault_in};
  end

  assign cfg_flat = regs_q;

  AST_REGS_HOLD: assert property (@(posedge clk) disable iff (!rst_n)
    !wr_en |=> $stable(regs_q)); // R3
endmodule

// File: rtl/i2c_strap_regslave.sv
`timescale 1ns/1ps
module i2c_strap_regslave
  import i2c_rs_pkg::*;
(
  input  logic                     clk,
  input  logic                     rst_n,
  input  logic [OFS_W-1:0]         strap_ofs,
  input  logic [FLT_W-1:0]         fault_in,
  input  logic                     scl_in,
  input  logic                     sda_in,
  output logic                     sda_pull,
  output logic [NUM_RW*BYTE_W-1:0] cfg_flat
);
  logic [1:0] line_s, line_q;
  logic start_ev, stop_ev, scl_rise, scl_fall;
  logic [DEV_AW-1:0] dev_addr;
  logic [BYTE_W-1:0] ptr, rd_data, wr_data;
  logic wr_en;

  assign dev_addr = DEV_BASE + DEV_AW'(strap_ofs);

  i2c_rs_sync #(.N_SIG(2), .STAGES(2)) u_sync (
    .clk    (clk),
    .rst_n  (rst_n),
    .sig_in ({sda_in, scl_in}),
    .sig_s  (line_s),
    .sig_q  (line_q)
  );

  i2c_rs_busevt u_evt (
    .scl_s    (line_s[0]),
    .scl_q    (line_q[0]),
    .sda_s    (line_s[1]),
    .sda_q    (line_q[1]),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall)
  );

  i2c_rs_fsm u_fsm (
    .clk      (clk),
    .rst_n    (rst_n),
    .start_ev (start_ev),
    .stop_ev  (stop_ev),
    .scl_rise (scl_rise),
    .scl_fall (scl_fall),
    .scl_s    (line_s[0]),
    .sda_s    (line_s[1]),
    .dev_addr (dev_addr),
    .rd_data  (rd_data),
    .ptr_o    (ptr),
    .wr_en    (wr_en),
    .wr_data  (wr_data),
    .sda_pull (sda_pull)
  );

  i2c_rs_regfile u_regs (
    .clk      (clk),
    .rst_n    (rst_n),
    .wr_en    (wr_en),
    .wr_addr  (ptr),
    .wr_data  (wr_data),
    .rd_addr  (ptr),
    .fault_in (fault_in),
    .rd_data  (rd_data),
    .cfg_flat (cfg_flat)
  );
endmodule

// File: tb/tb_i2c_strap_regslave.sv
`timescale 1ns/1ps
module tb_i2c_strap_regslave;
  import i2c_rs_pkg::*;

  localparam int Q = 10;
  localparam logic [6:0] DEV = 7'h71;
  localparam int NV = 14;
  localparam logic [15:0] DFLT_VEC [NV] = '{
    16'h0012, 16'h01FD, 16'h0204, 16'h0380, 16'h04CF, 16'h0651, 16'h080A,
    16'h10FF, 16'h11FC, 16'h1300, 16'h1402, 16'h0500, 16'h0700, 16'hFF00};

  logic clk = 1'b0;
  always #2.5 clk = ~clk;

  logic       rst_n;
  logic [2:0] strap;
  logic [3:0] faults;
  logic       m_scl, m_sda, sda_bus, sda_pull;
  logic [NUM_RW*BYTE_W-1:0] cfg;

  assign sda_bus = m_sda & ~sda_pull;

  i2c_strap_regslave dut (
    .clk       (clk),
    .rst_n     (rst_n),
    .strap_ofs (strap),
    .fault_in  (faults),
    .scl_in    (m_scl),
    .sda_in    (sda_bus),
    .sda_pull  (sda_pull),
    .cfg_flat  (cfg)
  );

  int n_chk = 0;
  int n_bad = 0;

  task automatic chk(input string req, input logic [31:0] act, input logic [31:0] exp);
    n_chk++;
    if (act !== exp) begin
      n_bad++;
      $display("FAIL %s: actual=%0h expected=%0h", req, act, exp);
    end
  endtask

  task automatic wq(input int n);
    repeat (n) @(negedge clk);
  endtask

  task automatic bus_start;
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b0; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic bus_stop;
    m_sda = 1'b0; wq(Q); m_scl = 1'b1; wq(Q); m_sda = 1'b1; wq(2*Q);
  endtask

  task automatic put_bit(input logic b);
    m_sda = b; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic put_byte(input logic [7:0] b, output logic ack);
    for (int i = 7; i >= 0; i--) put_bit(b[i]);
    m_sda = 1'b1; wq(Q); m_scl = 1'b1; wq(Q); ack = ~sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
  endtask

  task automatic get_byte(input logic give_ack, output logic [7:0] b, output logic rel);
    m_sda = 1'b1;
    for (int i = 7; i >= 0; i--) begin
      wq(Q); m_scl = 1'b1; wq(Q); b[i] = sda_bus; wq(Q); m_scl = 1'b0; wq(Q);
    end
    m_sda = ~give_ack; wq(Q); m_scl = 1'b1; wq(2*Q); m_scl = 1'b0; wq(Q);
    rel = ~sda_pull;
    m_sda = 1'b1;
  endtask

  task automatic do_write(input logic [6:0] dev, input logic [7:0] ptr,
                          input logic [31:0] dat, input int n, output logic [5:0] acks);
    logic a;
    acks = '0;
    bus_start;
    put_byte({dev, 1'b0}, a); acks[0] = a;
    put_byte(ptr, a);         acks[1] = a;
    for (int k = 0; k < n; k++) begin
      put_byte(dat[8*k +: 8], a); acks[2+k] = a;
    end
    bus_stop;
  endtask

  task automatic do_read(input logic [6:0] dev, input logic [7:0] ptr, input int n,
                         output logic [31:0] dat, output logic [2:0] acks, output logic rel);
    logic a;
    logic [7:0] b;
    dat = '0;
    bus_start;
    put_byte({dev, 1'b0}, a); acks[0] = a;
    put_byte(ptr, a);         acks[1] = a;
    bus_start;
    put_byte({dev, 1'b1}, a); acks[2] = a;
    for (int k = 0; k < n; k++) begin
      get_byte(k != n - 1, b, rel);
      dat[8*k +: 8] = b;
    end
    bus_stop;
  endtask

  initial begin
    wq(190000);
    n_chk++;
    n_bad++;
    $display("FAIL watchdog: actual=hung expected=done");
    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end

  initial begin
    logic [31:0] d;
    logic [5:0]  wa;
    logic [2:0]  ra;
    logic        rel;
    logic        a;

    rst_n = 1'b0; m_scl = 1'b1; m_sda = 1'b1; strap = 3'd5; faults = 4'hA;
    wq(10);
    rst_n = 1'b1;
    wq(10);

    // R6: reset state at the ports
    chk("R6 sda released after reset", {31'd0, sda_pull}, 32'd0);
    chk("R6 cfg 0x01 default", {24'd0, cfg[7:0]}, 32'hFD);

    // R6 R5 R7 R8: table of reset values read one by one
    for (int v = 0; v < NV; v++) begin
      do_read(DEV, DFLT_VEC[v][15:8], 1, d, ra, rel);
      chk($sformatf("R6 read of 0x%02h", DFLT_VEC[v][15:8]), d, {24'd0, DFLT_VEC[v][7:0]});
      chk("R1 acks on read", {29'd0, ra}, 32'd7);
    end
    chk("R4 release after NACK", {31'd0, rel}, 32'd1);

    // R2: wrong address is ignored
    do_write(7'h6C, 8'h04, 32'h55, 1, wa);
    chk("R2 no ack for other address", {26'd0, wa}, 32'd0);
    do_read(DEV, 8'h04, 1, d, ra, rel);
    chk("R2 register untouched", d, 32'hCF);

    // R3 R4: multi-byte write and read
    do_write(DEV, 8'h01, 32'h00332211, 3, wa);
    chk("R3 multi-write acks", {26'd0, wa}, 32'h1F);
    chk("R3 cfg after write", {8'd0, cfg[23:0]}, 32'h00332211);
    do_read(DEV, 8'h01, 3, d, ra, rel);
    chk("R4 multi-read data", d, 32'h00332211);
    chk("R4 release after last byte", {31'd0, rel}, 32'd1);

    // R5: id register is read-only
    do_write(DEV, 8'h00, 32'h55, 1, wa);
    chk("R5 write to id acked", {26'd0, wa}, 32'h07);
    do_read(DEV, 8'h00, 1, d, ra, rel);
    chk("R5 id unchanged", d, 32'h12);

    // R7: unimplemented address
    do_write(DEV, 8'h05, 32'h77, 1, wa);
    chk("R7 write acked", {26'd0, wa}, 32'h07);
    do_read(DEV, 8'h05, 1, d, ra, rel);
    chk("R7 read zero", d, 32'h00);

    // R8: fault register masking and live status
    do_write(DEV, 8'h08, 32'hFF, 1, wa);
    do_read(DEV, 8'h08, 1, d, ra, rel);
    chk("R8 masked write plus faults", d, 32'h3A);
    faults = 4'h5;
    do_read(DEV, 8'h08, 1, d, ra, rel);
    chk("R8 live fault bits", d, 32'h35);

    // R9: pointer wrap on read and write
    do_read(DEV, 8'hFF, 2, d, ra, rel);
    chk("R9 read wrap", d, 32'h1200);
    do_write(DEV, 8'hFF, 32'h00C86644, 3, wa);
    do_read(DEV, 8'h01, 1, d, ra, rel);
    chk("R9 write wrap", d, 32'hC8);

    // R10: start in the middle of a data byte drops it
    bus_start;
    put_byte({DEV, 1'b0}, a);
    put_byte(8'h04, a);
    for (int i = 0; i < 4; i++) put_bit(1'b0);
    do_read(DEV, 8'h04, 1, d, ra, rel);
    chk("R10 aborted byte not stored", d, 32'hCF);
    chk("R10 new address phase acked", {29'd0, ra}, 32'd7);

    // R1: address follows the strap offset
    strap = 3'd0;
    wq(4);
    do_read(7'h6C, 8'h00, 1, d, ra, rel);
    chk("R1 base address acked", {29'd0, ra}, 32'd7);
    chk("R1 base address data", d, 32'h12);
    do_write(7'h71, 8'h04, 32'h00, 1, wa);
    chk("R1 old address ignored", {26'd0, wa}, 32'd0);

    $display("*** SUMMARY: %0d compared / %0d mismatched ***", n_chk, n_bad);
    $finish;
  end
endmodule